// File: doc/BRIEF.md
# Calendar Counter with Interrupt Selection

This block keeps time of day and calendar position as a chain of five counters (seconds, minutes, hours, day number and weekday), stepped by a prescaled one-second tick. The tick comes from one of two sources: a slow default source or a faster alternate. A control word selects the source. The same word enables the counter clock, enables counting, and picks which boundary of the chain raises the periodic interrupt.

Software first writes five preset values. It then sets the clock-enable bit. A fixed number of clocks later, all five presets move into the live counters in a single transfer, and counting starts from there. A single-cycle periodic pulse and a single-cycle overflow pulse are produced. The overflow pulse fires only when the whole chain wraps in the same step. Each pulse also sets a sticky flag, which software clears. The live counters are driven onto output ports so that a bus can read them.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, all five counters, all presets, the control state and both flags are 0. The slow tick source is selected and no interrupt pulses.
- R2: A counter steps only when all four conditions hold: clock-enable is 1, count-enable is 1, the preset load has completed, and the selected tick is high. When either enable is 0, every counter holds its value.
- R3: The source bit selects the tick: 0 means tick_slow and 1 means tick_fast. The unselected tick has no effect. A control write changes the source bit only if clock-enable was 0 before that write.
- R4: Presets are written by address: 0 is second, 1 is minute, 2 is hour, 3 is day and 4 is weekday. The clock-enable bit sets at edge E0, and all five presets load together at edge E0+LOAD_DELAY (default 3). Ticks before and during that edge do not count. Clearing clock-enable re-arms the load for the next enable.
- R5: Seconds wrap after SEC_MAX and carry into minutes. Minutes wrap after MIN_MAX and carry into hours. The hour carry steps both the day counter (which wraps after DAY_MAX) and the weekday counter (which wraps after WEEK_MAX).
- R6: per_irq pulses for one cycle, on the counting edge, when the selected event occurs. The select codes are: 4'b0111 for every step, 4'b1000 for a seconds wrap, 4'b1001 for a minutes wrap, 4'b1010 for an hours wrap, and 4'b1011 for a weekday wrap. All other codes never pulse.
- R7: ovf_irq pulses for one cycle when seconds, minutes, hours, day and weekday all wrap in the same step. After that step all counters read 0.
- R8: per_flag and ovf_flag set on their pulses and clear on flag_clr_per and flag_clr_ovf. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_slow | input | 1 | One-cycle tick from the default slow source |
| tick_fast | input | 1 | One-cycle tick from the alternate source |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_clk_en | input | 1 | Clock-enable value to write |
| ctrl_cnt_en | input | 1 | Count-enable value to write |
| ctrl_src | input | 1 | Source-select value to write |
| ctrl_isel | input | 4 | Periodic interrupt select code to write |
| pre_we | input | 1 | Preset write strobe |
| pre_addr | input | 3 | Preset field address |
| pre_data | input | CNT_W | Preset value |
| flag_clr_per | input | 1 | Clear periodic flag |
| flag_clr_ovf | input | 1 | Clear overflow flag |
| cnt_sec | output | CNT_W | Seconds counter |
| cnt_min | output | CNT_W | Minutes counter |
| cnt_hour | output | CNT_W | Hours counter |
| cnt_day | output | CNT_W | Day counter |
| cnt_week | output | CNT_W | Weekday counter |
| per_irq | output | 1 | Periodic interrupt pulse |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| per_flag | output | 1 | Sticky periodic flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong carry or wrap value appears on the count ports at the negative edge after the faulty step. It also moves per_irq or ovf_irq off their expected ticks, so a sweep that compares every step against an arithmetic model reports the fault within one tick. An off-by-one load delay shows up within three clocks of enabling the clock, because the ports show either the old or the preset values on the wrong cycle. Day and weekday misalignment only becomes visible at the overflow tick, so the bench uses small maxima and runs the full joint period of the chain.

// File: rtl/rtc_cal_pkg.sv
// Shared constants for the calendar counter: field indices and
// periodic-interrupt select codes. Assumes five chained fields.
package rtc_cal_pkg;
    localparam int NF     = 5;
    localparam int ADDR_W = 3;

    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DAY  = 3;
    localparam int FLD_WEEK = 4;

    localparam logic [3:0] ISEL_STEP = 4'b0111;
    localparam logic [3:0] ISEL_MIN  = 4'b1000;
    localparam logic [3:0] ISEL_HOUR = 4'b1001;
    localparam logic [3:0] ISEL_DAY  = 4'b1010;
    localparam logic [3:0] ISEL_WEEK = 4'b1011;
endpackage

// File: rtl/rtc_ctrl.sv
// Control state and load sequencer. Holds the enable bits, the source
// select (locked while the clock is enabled) and the interrupt select.
// After clock-enable rises, counts LOAD_DELAY clocks and then issues one
// load pulse; counting is allowed only after that pulse.
// Assumes LOAD_DELAY >= 1.
module rtc_ctrl #(
    parameter int LOAD_DELAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       ctrl_clk_en,
    input  logic       ctrl_cnt_en,
    input  logic       ctrl_src,
    input  logic [3:0] ctrl_isel,
    input  logic       tick_slow,
    input  logic       tick_fast,
    output logic [3:0] isel_q,
    output logic       load_pulse,
    output logic       step
);
    localparam int DW = $clog2(LOAD_DELAY + 1);

    logic          clk_en_q;
    logic          cnt_en_q;
    logic          src_q;
    logic          loaded_q;
    logic [DW-1:0] dly_q;
    logic          tick_sel;

    // Control word register; the source bit only moves while the clock is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            cnt_en_q <= 1'b0;
            src_q    <= 1'b0;
            isel_q   <= '0;
        end else if (ctrl_we) begin
            clk_en_q <= ctrl_clk_en;
            cnt_en_q <= ctrl_cnt_en;
            isel_q   <= ctrl_isel;
            if (!clk_en_q) begin
                src_q <= ctrl_src;
            end
        end
    end

    // Delay counter and load-done state; re-armed whenever the clock is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !clk_en_q) begin
            dly_q    <= '0;
            loaded_q <= 1'b0;
        end else if (!loaded_q) begin
            if (load_pulse) begin
                loaded_q <= 1'b1;
                dly_q    <= '0;
            end else begin
                dly_q <= dly_q + 1'b1;
            end
        end
    end

    // Load strobe on the last delay clock; step on a selected tick once loaded.
    always_comb begin
        load_pulse = clk_en_q && !loaded_q && (dly_q == DW'(LOAD_DELAY - 1));
        tick_sel   = src_q ? tick_fast : tick_slow;
        step       = clk_en_q && cnt_en_q && loaded_q && tick_sel;
    end
endmodule

// File: rtl/rtc_digit.sv
// One wrapping counter of the chain. Loads a preset on load, otherwise
// advances on inc and wraps to 0 after MAX. carry marks a wrapping step.
// Assumes load and inc never coincide.
module rtc_digit #(
    parameter int W   = 8,
    parameter int MAX = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);
    // Wrap condition for this step.
    always_comb carry = inc && (val >= W'(MAX));

    // Value register: preset load, increment or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (inc) begin
            val <= carry ? '0 : val + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_event.sv
// Interrupt generation. Registers a one-cycle periodic pulse for the
// selected chain event and an overflow pulse when day and weekday wrap in
// the same step, and keeps a sticky flag for each (set beats clear).
module rtc_event
    import rtc_cal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [NF-1:0] carry,
    input  logic [3:0]    isel,
    input  logic          clr_per,
    input  logic          clr_ovf,
    output logic          per_irq,
    output logic          ovf_irq,
    output logic          per_flag,
    output logic          ovf_flag
);
    logic per_evt;
    logic ovf_evt;

    // Decode the select code into the chosen chain event.
    always_comb begin
        case (isel)
            ISEL_STEP: per_evt = step;
            ISEL_MIN:  per_evt = carry[FLD_SEC];
            ISEL_HOUR: per_evt = carry[FLD_MIN];
            ISEL_DAY:  per_evt = carry[FLD_HOUR];
            ISEL_WEEK: per_evt = carry[FLD_WEEK];
            default:   per_evt = 1'b0;
        endcase
        ovf_evt = carry[FLD_DAY] && carry[FLD_WEEK];
    end

    // Pulse registers and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_irq  <= 1'b0;
            ovf_irq  <= 1'b0;
            per_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            per_irq  <= per_evt;
            ovf_irq  <= ovf_evt;
            per_flag <= per_evt || (per_flag && !clr_per);
            ovf_flag <= ovf_evt || (ovf_flag && !clr_ovf);
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
// Calendar counter top: preset registers, five chained digits, control
// sequencer and interrupt logic. Counters are read straight from ports.
// Assumes every *_MAX fits in CNT_W bits.
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SEC_MAX    = 59,
    parameter int MIN_MAX    = 59,
    parameter int HOUR_MAX   = 23,
    parameter int DAY_MAX    = 30,
    parameter int WEEK_MAX   = 6,
    parameter int LOAD_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              ctrl_we,
    input  logic              ctrl_clk_en,
    input  logic              ctrl_cnt_en,
    input  logic              ctrl_src,
    input  logic [3:0]        ctrl_isel,
    input  logic              pre_we,
    input  logic [2:0]        pre_addr,
    input  logic [CNT_W-1:0]  pre_data,
    input  logic              flag_clr_per,
    input  logic              flag_clr_ovf,
    output logic [CNT_W-1:0]  cnt_sec,
    output logic [CNT_W-1:0]  cnt_min,
    output logic [CNT_W-1:0]  cnt_hour,
    output logic [CNT_W-1:0]  cnt_day,
    output logic [CNT_W-1:0]  cnt_week,
    output logic              per_irq,
    output logic              ovf_irq,
    output logic              per_flag,
    output logic              ovf_flag
);
    localparam int MAXV [NF] = '{SEC_MAX, MIN_MAX, HOUR_MAX, DAY_MAX, WEEK_MAX};

    logic [3:0]       isel_q;
    logic             load_pulse;
    logic             step;
    logic [NF-1:0]    inc;
    logic [NF-1:0]    carry;
    logic [CNT_W-1:0] cnt   [NF];
    logic [CNT_W-1:0] pre_q [NF];

    rtc_ctrl #(.LOAD_DELAY(LOAD_DELAY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_clk_en(ctrl_clk_en),
        .ctrl_cnt_en(ctrl_cnt_en),
        .ctrl_src   (ctrl_src),
        .ctrl_isel  (ctrl_isel),
        .tick_slow  (tick_slow),
        .tick_fast  (tick_fast),
        .isel_q     (isel_q),
        .load_pulse (load_pulse),
        .step       (step)
    );

    for (genvar g = 0; g < NF; g++) begin : g_fld
        // Preset register for this field, written by address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[g] <= '0;
            end else if (pre_we && pre_addr == ADDR_W'(g)) begin
                pre_q[g] <= pre_data;
            end
        end

        if (g == FLD_SEC) begin : g_first
            assign inc[g] = step;
        end else if (g >= FLD_DAY) begin : g_cal
            assign inc[g] = carry[FLD_HOUR];
        end else begin : g_chain
            assign inc[g] = carry[g-1];
        end

        rtc_digit #(.W(CNT_W), .MAX(MAXV[g])) u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_pulse),
            .load_val(pre_q[g]),
            .inc     (inc[g]),
            .val     (cnt[g]),
            .carry   (carry[g])
        );
    end

    rtc_event u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .carry   (carry),
        .isel    (isel_q),
        .clr_per (flag_clr_per),
        .clr_ovf (flag_clr_ovf),
        .per_irq (per_irq),
        .ovf_irq (ovf_irq),
        .per_flag(per_flag),
        .ovf_flag(ovf_flag)
    );

    assign cnt_sec  = cnt[FLD_SEC];
    assign cnt_min  = cnt[FLD_MIN];
    assign cnt_hour = cnt[FLD_HOUR];
    assign cnt_day  = cnt[FLD_DAY];
    assign cnt_week = cnt[FLD_WEEK];
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar, attached by bind below. Relates the
// sequencer strobes to counter and interrupt behaviour over time.
module rtc_calendar_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_pulse,
    input logic             step,
    input logic [CNT_W-1:0] cnt_sec,
    input logic [CNT_W-1:0] cnt_min,
    input logic [CNT_W-1:0] cnt_hour,
    input logic [CNT_W-1:0] cnt_day,
    input logic [CNT_W-1:0] cnt_week,
    input logic             per_irq,
    input logic             ovf_irq,
    input logic             per_flag,
    input logic             ovf_flag
);
    logic seen_q;

    // Marks that at least one clock out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(step) && !$past(load_pulse)
        |-> $stable({cnt_sec, cnt_min, cnt_hour, cnt_day, cnt_week}));

    p_load_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);

    p_no_step_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pulse && step));

    p_per_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && per_irq |-> $past(step));

    p_ovf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (cnt_sec == '0 && cnt_min == '0 && cnt_hour == '0
                     && cnt_day == '0 && cnt_week == '0));

    p_per_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_irq |-> per_flag);

    p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_flag);
endmodule

bind rtc_calendar rtc_calendar_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_pulse(load_pulse),
    .step      (step),
    .cnt_sec   (cnt_sec),
    .cnt_min   (cnt_min),
    .cnt_hour  (cnt_hour),
    .cnt_day   (cnt_day),
    .cnt_week  (cnt_week),
    .per_irq   (per_irq),
    .ovf_irq   (ovf_irq),
    .per_flag  (per_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/rtc_calendar_test.sv
// Bench: small chain maxima so a full joint period (900 steps) is swept
// for every select code, compared against an arithmetic model.
module rtc_calendar_test;
    localparam int CW = 8;
    localparam int SM = 4, MM = 3, HM = 2, DM = 4, WM = 2, LD = 3;
    localparam int PERIOD = (SM+1)*(MM+1)*(HM+1)*15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_slow = 0, tick_fast = 0;
    logic ctrl_we = 0, ctrl_clk_en = 0, ctrl_cnt_en = 0, ctrl_src = 0;
    logic [3:0] ctrl_isel = '0;
    logic pre_we = 0;
    logic [2:0] pre_addr = '0;
    logic [CW-1:0] pre_data = '0;
    logic flag_clr_per = 0, flag_clr_ovf = 0;
    logic [CW-1:0] cnt_sec, cnt_min, cnt_hour, cnt_day, cnt_week;
    logic per_irq, ovf_irq, per_flag, ovf_flag;

    int checks = 0;
    int failures = 0;
    int m [5];
    int mx [5] = '{SM, MM, HM, DM, WM};
    logic [3:0] cur_isel = '0;
    bit exp_per, exp_ovf;

    always #5 clk = ~clk;

    rtc_calendar #(.CNT_W(CW), .SEC_MAX(SM), .MIN_MAX(MM), .HOUR_MAX(HM),
                   .DAY_MAX(DM), .WEEK_MAX(WM), .LOAD_DELAY(LD)) uut (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .ctrl_we(ctrl_we), .ctrl_clk_en(ctrl_clk_en), .ctrl_cnt_en(ctrl_cnt_en),
        .ctrl_src(ctrl_src), .ctrl_isel(ctrl_isel), .pre_we(pre_we),
        .pre_addr(pre_addr), .pre_data(pre_data), .flag_clr_per(flag_clr_per),
        .flag_clr_ovf(flag_clr_ovf), .cnt_sec(cnt_sec), .cnt_min(cnt_min),
        .cnt_hour(cnt_hour), .cnt_day(cnt_day), .cnt_week(cnt_week),
        .per_irq(per_irq), .ovf_irq(ovf_irq), .per_flag(per_flag), .ovf_flag(ovf_flag));

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " sec"},  int'(cnt_sec),  m[0]);
        chk({tag, " min"},  int'(cnt_min),  m[1]);
        chk({tag, " hour"}, int'(cnt_hour), m[2]);
        chk({tag, " day"},  int'(cnt_day),  m[3]);
        chk({tag, " week"}, int'(cnt_week), m[4]);
    endtask

    // One clock with the given ticks; returns at the following negedge.
    task automatic cyc(input bit s, input bit f);
        tick_slow = s; tick_fast = f;
        @(negedge clk);
        tick_slow = 0; tick_fast = 0;
    endtask

    task automatic wr_ctrl(input bit ce, input bit cn, input bit src, input logic [3:0] isel);
        ctrl_we = 1; ctrl_clk_en = ce; ctrl_cnt_en = cn; ctrl_src = src; ctrl_isel = isel;
        @(negedge clk);
        ctrl_we = 0;
        cur_isel = isel;
    endtask

    task automatic wr_pre(input int a, input int d);
        pre_we = 1; pre_addr = 3'(a); pre_data = CW'(d);
        @(negedge clk);
        pre_we = 0;
    endtask

    // Model of one counting step (R5 wraps, R6 select codes, R7 overflow).
    task automatic model_step();
        bit c0, c1, c2, c3, c4;
        c0 = (m[0] == SM);
        c1 = c0 && (m[1] == MM);
        c2 = c1 && (m[2] == HM);
        c3 = c2 && (m[3] == DM);
        c4 = c2 && (m[4] == WM);
        case (cur_isel)
            4'b0111: exp_per = 1;
            4'b1000: exp_per = c0;
            4'b1001: exp_per = c1;
            4'b1010: exp_per = c2;
            4'b1011: exp_per = c4;
            default: exp_per = 0;
        endcase
        exp_ovf = c3 && c4;
        m[0] = c0 ? 0 : m[0] + 1;
        if (c0) m[1] = c1 ? 0 : m[1] + 1;
        if (c1) m[2] = c2 ? 0 : m[2] + 1;
        if (c2) begin
            m[3] = c3 ? 0 : m[3] + 1;
            m[4] = c4 ? 0 : m[4] + 1;
        end
    endtask

    initial begin
        logic [3:0] codes [7] = '{4'b0111, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b0000, 4'b1111};
        int ovf_seen;
        int per_seen;
        for (int i = 0; i < 5; i++) m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk_counts("R1 reset");
        chk("R1 per_irq", per_irq, 0);
        chk("R1 ovf_irq", ovf_irq, 0);
        chk("R1 per_flag", per_flag, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        // R1/R3: after reset the slow source is selected with clock off: nothing moves
        cyc(1, 1);
        chk_counts("R1 idle hold");

        // R4: presets and delayed parallel load
        wr_pre(0, 3); wr_pre(1, 2); wr_pre(2, 1); wr_pre(3, 4); wr_pre(4, 2);
        wr_ctrl(1, 1, 0, 4'b0111);
        cyc(1, 0);
        chk_counts("R4 before load E1");
        cyc(1, 0);
        chk_counts("R4 before load E2");
        cyc(1, 0);
        m = '{3, 2, 1, 4, 2};
        chk_counts("R4 load at E3");
        chk("R4 no per on load", per_irq, 0);

        // R5/R6/R7: full-period sweep per select code
        foreach (codes[k]) begin
            wr_ctrl(1, 1, 0, codes[k]);
            ovf_seen = 0;
            per_seen = 0;
            for (int t = 0; t < PERIOD; t++) begin
                cyc(1, 0);
                model_step();
                chk_counts("R5 sweep");
                chk("R6 per_irq", per_irq, exp_per);
                chk("R7 ovf_irq", ovf_irq, exp_ovf);
                ovf_seen += ovf_irq;
                per_seen += per_irq;
            end
            chk("R7 one overflow per period", ovf_seen, 1);
            if (k >= 5) chk("R6 unused code silent", per_seen, 0);
        end

        // R3: unselected tick ignored; R2 no tick holds
        cyc(0, 1);
        chk_counts("R3 fast ignored");
        cyc(0, 0);
        chk_counts("R2 no tick hold");

        // R8: flags set by sweep, independent clears, set wins
        chk("R8 per_flag set", per_flag, 1);
        chk("R8 ovf_flag set", ovf_flag, 1);
        wr_ctrl(1, 1, 0, 4'b0111);
        flag_clr_per = 1;
        cyc(1, 0);
        model_step();
        flag_clr_per = 0;
        chk("R8 set beats clear", per_flag, 1);
        chk_counts("R8 step during clear");
        flag_clr_per = 1;
        cyc(0, 0);
        flag_clr_per = 0;
        chk("R8 per_flag cleared", per_flag, 0);
        chk("R8 ovf_flag kept", ovf_flag, 1);
        flag_clr_ovf = 1;
        cyc(0, 0);
        flag_clr_ovf = 0;
        chk("R8 ovf_flag cleared", ovf_flag, 0);

        // R3: source write ignored while clock enabled
        wr_ctrl(1, 1, 1, 4'b0111);
        cyc(0, 1);
        chk_counts("R3 src locked fast ignored");
        cyc(1, 0);
        model_step();
        chk_counts("R3 src locked slow counts");

        // R2: clock off holds, src write with old enable=1 still ignored
        wr_ctrl(0, 1, 1, 4'b0111);
        cyc(1, 1);
        chk_counts("R2 clock off hold");
        wr_ctrl(0, 1, 1, 4'b0111);   // now takes src=1

        // R4: re-armed load with new presets
        wr_pre(0, 1); wr_pre(1, 3); wr_pre(2, 2); wr_pre(3, 0); wr_pre(4, 1);
        cyc(0, 0);
        chk_counts("R4 presets not live while off");
        wr_ctrl(1, 1, 1, 4'b0111);
        cyc(0, 1);
        cyc(0, 1);
        chk_counts("R4 rearm before load");
        cyc(0, 1);
        m = '{1, 3, 2, 0, 1};
        chk_counts("R4 rearm load");
        cyc(1, 0);
        chk_counts("R3 slow ignored when fast selected");
        cyc(0, 1);
        model_step();
        chk_counts("R3 fast counts");
        chk("R6 per on fast step", per_irq, 1);

        // R2: count-enable off holds with clock still on
        wr_ctrl(1, 0, 1, 4'b0111);
        cyc(0, 1);
        chk_counts("R2 count off hold");
        chk("R2 no per when held", per_irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule